// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between a half-bridge oscillator and the two gate drivers. It turns a single phase request into non-overlapping high-side and low-side gate commands, and it inserts a dead interval before each gate turns on.

After the high-side gate turns off, the low-side gate turns on as soon as a digital flag reports that the switch node has reached ground. The length of that interval is measured in clock cycles and kept. The kept value is then used as the dead interval from low-side off to high-side on, so the measurement repeats on every oscillator period. A short blanking window after turn-off masks the flag so that ringing cannot cut the interval short. If the switch node never slews, a maximum default interval applies, about 1 µs at the default 50 MHz clock.

Top module: `adt_ctrl`

## Requirements
- R1: While `en_i` is low, `ho_o` and `lo_o` are both low in the same cycle, and stay low. After reset both outputs are low.
- R2: After enable, the first gate to turn on is the low side. `lo_o` rises on the first clock edge at which `en_i` is high and `phase_i` is 0. While `phase_i` is 1 in the idle state, both outputs stay low.
- R3: `phase_i` = 1 requests the high side and `phase_i` = 0 requests the low side. When `ho_o` falls, `lo_o` rises k clock cycles later, where k is the first count, with k >= BLANK (default 4), at whose edge `sw_low_i` is sampled high. The count is 1 at the first edge after `ho_o` falls.
- R4: A `sw_low_i` pulse that is seen only at counts below BLANK is ignored. A flag that is held high across the blanking window is accepted at count BLANK.
- R5: If `sw_low_i` is not accepted by count DT_MAX (default 50), `lo_o` rises DT_MAX cycles after `ho_o` falls.
- R6: When `phase_i` rises, `lo_o` falls at the next edge. `ho_o` rises exactly as many cycles later as the most recent low-side dead interval measured under R3 to R5.
- R7: The stored interval is DT_MAX after reset and after any cycle in which `en_i` is low.
- R8: `ho_o` and `lo_o` are never high in the same cycle, even when `sw_low_i` glitches.
- R9: Every new low-side dead interval replaces the stored value, so each period adapts to the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces both gates off |
| phase_i | input | 1 | Phase request from the oscillator: 1 = high side, 0 = low side |
| sw_low_i | input | 1 | Switch node detected at ground |
| ho_o | output | 1 | High-side gate command |
| lo_o | output | 1 | Low-side gate command |

## Verification
A table of slew timings is applied. It includes flag arrivals that land inside the window, right at the blanking edge, early but held, early as a single-cycle glitch, past the maximum, and never. Each one separates blanking, acceptance and fallback behaviour. Every measured low-side interval is then checked against the following high-side interval, which shows whether the value was mirrored and replaced each period rather than stuck. Directed tests cover the reset state, the low-side-first start, the immediate effect of disable, and the return of the stored value to its maximum after re-enable.

// File: rtl/adt_pkg.sv
package adt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HI    = 3'd1,
    ST_DT_HL = 3'd2,
    ST_LO    = 3'd3,
    ST_DT_LH = 3'd4
  } adt_state_e;
endpackage

// File: rtl/adt_dead_counter.sv
module adt_dead_counter #(
  parameter int DT_MAX = 50,
  localparam int CNT_W = $clog2(DT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(DT_MAX);

  // clear loads 1: the count equals dead cycles elapsed at the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= CNT_W'(1);
    else if (cnt_o < MAX_C) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= MAX_C); // R5
endmodule

// File: rtl/adt_hold_reg.sv
module adt_hold_reg #(
  parameter int DT_MAX = 50,
  parameter int BLANK  = 4,
  localparam int CNT_W = $clog2(DT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] held_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(DT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_o <= MAX_C;
    else if (!en_i) held_o <= MAX_C;
    else if (ld_i)  held_o <= val_i;
  end

  AST_HOLD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o >= CNT_W'(BLANK)) && (held_o <= MAX_C)); // R9
  AST_HOLD_DIS_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> held_o == MAX_C); // R7
endmodule

// File: rtl/adt_phase_fsm.sv
module adt_phase_fsm
  import adt_pkg::*;
#(
  parameter int DT_MAX = 50,
  parameter int BLANK  = 4,
  localparam int CNT_W = $clog2(DT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             phase_i,
  input  logic             sw_low_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] held_i,
  output logic             cnt_clr_o,
  output logic             hold_ld_o,
  output logic             ho_o,
  output logic             lo_o
);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(DT_MAX);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  adt_state_e state_q, state_d;
  logic       slew_ok;

  assign slew_ok = (sw_low_i && (cnt_i >= BLANK_C)) || (cnt_i >= MAX_C);

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    hold_ld_o = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (!phase_i) state_d = ST_LO;
        ST_HI:    if (!phase_i) begin
                    state_d   = ST_DT_HL;
                    cnt_clr_o = 1'b1;
                  end
        ST_DT_HL: if (slew_ok) begin
                    state_d   = ST_LO;
                    hold_ld_o = 1'b1;
                  end
        ST_LO:    if (phase_i) begin
                    state_d   = ST_DT_LH;
                    cnt_clr_o = 1'b1;
                  end
        ST_DT_LH: if (cnt_i >= held_i) state_d = ST_HI;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ho_o = en_i && (state_q == ST_HI);
  assign lo_o = en_i && (state_q == ST_LO);

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ho_o && lo_o)); // R8
  AST_HO_NEEDS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ho_o) |-> !$past(lo_o)); // R6
  AST_BLANK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DT_HL && cnt_i < BLANK_C && en_i) |=> !lo_o); // R4
  AST_MAX_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DT_HL && cnt_i >= MAX_C && en_i && $past(en_i)) |=> (lo_o || !en_i)); // R5
  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!ho_o && !lo_o)); // R1
endmodule

// File: rtl/adt_ctrl.sv
module adt_ctrl #(
  parameter int DT_MAX = 50,
  parameter int BLANK  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic phase_i,
  input  logic sw_low_i,
  output logic ho_o,
  output logic lo_o
);
  localparam int CNT_W = $clog2(DT_MAX + 1);

  logic [CNT_W-1:0] cnt, held;
  logic             cnt_clr, hold_ld;

  adt_dead_counter #(.DT_MAX(DT_MAX)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  adt_hold_reg #(.DT_MAX(DT_MAX), .BLANK(BLANK)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .ld_i  (hold_ld),
    .val_i (cnt),
    .held_o(held)
  );

  adt_phase_fsm #(.DT_MAX(DT_MAX), .BLANK(BLANK)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .phase_i  (phase_i),
    .sw_low_i (sw_low_i),
    .cnt_i    (cnt),
    .held_i   (held),
    .cnt_clr_o(cnt_clr),
    .hold_ld_o(hold_ld),
    .ho_o     (ho_o),
    .lo_o     (lo_o)
  );
endmodule

// File: tb/tb_adt_ctrl.sv
module tb_adt_ctrl;
  localparam int CLK_PERIOD = 20;
  localparam int DT_MAX = 50;
  localparam int BLANK  = 4;
  localparam int NVEC   = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, phase = 1'b1, sw_low = 1'b0;
  logic ho, lo;
  int   n_chk = 0, n_bad = 0;
  int   held_exp;
  bit   overlap_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adt_ctrl #(.DT_MAX(DT_MAX), .BLANK(BLANK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .phase_i(phase),
    .sw_low_i(sw_low), .ho_o(ho), .lo_o(lo)
  );

  always @(negedge clk) if (ho && lo) overlap_seen = 1'b1;

  // {flag count k (0 = never), flag held (1) or single pulse (0), expected dead}
  localparam int VEC [NVEC][3] = '{
    '{15, 1, 15}, '{20, 1, 20}, '{ 4, 1,  4}, '{ 2, 1,  4}, '{ 2, 0, 50},
    '{ 0, 0, 50}, '{33, 1, 33}, '{50, 1, 50}, '{60, 1, 50}, '{ 6, 0,  6}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // HO falls; flag driven per vector; returns dead cycles before LO rises
  task automatic measure_hl(input int k, input int lvl, output int dead);
    @(negedge clk) phase = 1'b0;
    dead = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (lo) break;
      dead++;
      sw_low = (k != 0) && (lvl ? (i >= k) : (i == k));
    end
    sw_low = 1'b0;
  endtask

  task automatic measure_lh(output int dead);
    @(negedge clk) phase = 1'b1;
    dead = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (ho) break;
      dead++;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int d;
    // R1 reset state
    #(CLK_PERIOD * 2 + 3);
    check("R1 reset ho", ho, 0);
    check("R1 reset lo", lo, 0);
    rst_n = 1'b1;
    // R2 idle with high-side request: nothing turns on
    @(negedge clk) en = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 idle ho", ho, 0);
    check("R2 idle lo", lo, 0);
    @(negedge clk) phase = 1'b0;
    @(negedge clk);
    check("R2 low side first", lo, 1);
    repeat (2) @(negedge clk);
    held_exp = DT_MAX;   // R7 after reset
    // table: R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      measure_lh(d);
      check("R6 mirrored dead", d, held_exp);
      repeat (2) @(negedge clk);
      measure_hl(VEC[v][0], VEC[v][1], d);
      check("R3/R4/R5 measured dead", d, VEC[v][2]);
      held_exp = VEC[v][2];   // R9 replaces each period
      repeat (2) @(negedge clk);
    end
    // R1 disable is immediate, R7 held returns to max
    measure_lh(d);
    check("R6 last mirror", d, held_exp);
    @(negedge clk) en = 1'b0;
    #1;
    check("R1 disable ho", ho, 0);
    check("R1 disable lo", lo, 0);
    phase = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stays low", ho | lo, 0);
    en = 1'b1;
    @(negedge clk);
    check("R2 restart lo", lo, 1);
    measure_lh(d);
    check("R7 held back to max", d, DT_MAX);
    check("R8 overlap never seen", overlap_seen, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule